// File: doc/BRIEF.md
# Quadrature Rotation Sine Oscillator

This block generates a running pair of sine and cosine samples at one fixed frequency. It uses no phase table. It holds the current pair in two signed fixed-point registers. On every enabled clock it turns that pair through a constant step angle, using the angle-addition identities. Each step costs four multiplies and two adds. The caller supplies the step as two constants, the sine and the cosine of the step angle, and a new pair appears on every enabled cycle for as long as the block runs.

Samples and constants share one signed format, Q1.14 by default: 16 bits with 14 fraction bits, so that 1.0 is exactly representable. Each rotated value is rounded to nearest and clamped to the signed range before it is written back. A load path lets the caller place any pair in the state, for example to start at another phase or amplitude. Reset returns the state to angle zero at full scale. The block does not derive the constants from a frequency word and never renormalises the amplitude. The long-term amplitude therefore depends on how close the two constants lie to the unit circle.

Top module: `qrot_osc`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets sin_out to 0, cos_out to 2^FRAC (16384 by default) and out_valid to 0 after that edge. Reset takes priority over load and en.
- R2: After an edge with en high and load low, sin_out becomes round(sin·k_cos + cos·k_sin), where round(x) = (x + 2^(FRAC-1)) arithmetically shifted right by FRAC.
- R3: After the same edge, cos_out becomes round(cos·k_cos − sin·k_sin), using the same rounding.
- R4: A rotated result outside the signed DW-bit range is clamped to the range: 32767 at the top and −32768 at the bottom by default. It never wraps.
- R5: After an edge with en low and load low, sin_out and cos_out keep their values and out_valid is 0.
- R6: out_valid is 1 after every edge with en high and load low, so consecutive enabled cycles give one new pair per clock.
- R7: After an edge with load high and rst low, sin_out equals ld_sin, cos_out equals ld_cos and out_valid is 0, whatever the value of en.
- R8: With constants within one LSB of a unit vector at step angle θ, the first 2000 samples after reset stay within 164 LSB (0.01 of full scale) of 16384·sin(nθ) and 16384·cos(nθ).
- R9: With constants chosen so that k_sin² + k_cos² lies close to 2^28, the amplitude sqrt(sin² + cos²) stays within 3 % of 16384 over 10,000 consecutive samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the rotation by one step this cycle |
| load | input | 1 | Write ld_sin and ld_cos into the state |
| ld_sin | input | DW | Sine value for load, signed Q1.FRAC |
| ld_cos | input | DW | Cosine value for load, signed Q1.FRAC |
| k_sin | input | DW | Sine of the step angle, signed Q1.FRAC |
| k_cos | input | DW | Cosine of the step angle, signed Q1.FRAC |
| sin_out | output | DW | Current sine sample, signed Q1.FRAC |
| cos_out | output | DW | Current cosine sample, signed Q1.FRAC |
| out_valid | output | 1 | A fresh rotated pair is on the outputs |

## Verification
The state is the output, so a wrong bit in either register appears at the ports in the very cycle after the edge that wrote it. Every later sample then carries the error forward, because each pair is computed from the one before. A wrong rounding or sign choice alters the sample one cycle after the first step where it matters. Over thousands of steps it also shows up as a slow growth or decay of the amplitude. For that reason the bench compares every sample bit for bit against an integer model, and also tracks the amplitude and phase against real-valued trigonometry. A clamp that wraps instead shows as a jump of a full range in the cycle after an overflowing step.

// File: rtl/qrot_pkg.sv
package qrot_pkg;

  // Sign applied to the second product of a rotation lane
  typedef enum logic {
    ROT_ADD = 1'b0,
    ROT_SUB = 1'b1
  } rot_op_e;

  // Lane indices inside the rotator
  localparam int LANE_SIN = 0;
  localparam int LANE_COS = 1;
  localparam int NUM_LANES = 2;

endpackage

// File: rtl/qrot_rotmac.sv
// One rotation lane: y = sat(round(a*b +/- c*d)), fixed point with FRAC fraction bits
module qrot_rotmac
  import qrot_pkg::*;
#(
  parameter int      DW   = 16,
  parameter int      FRAC = 14,
  parameter rot_op_e OP   = ROT_ADD
) (
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  input  logic signed [DW-1:0] c,
  input  logic signed [DW-1:0] d,
  output logic signed [DW-1:0] y
);

  localparam int PW = 2 * DW;
  localparam int SW = PW + 1;
  localparam logic signed [SW-1:0] HALF = SW'(1) << (FRAC - 1);
  localparam logic signed [SW-1:0] MAXV = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [PW-1:0] prod_ab;
  logic signed [PW-1:0] prod_cd;
  logic signed [SW-1:0] ext_ab;
  logic signed [SW-1:0] ext_cd;
  logic signed [SW-1:0] acc;
  logic signed [SW-1:0] rounded;
  logic signed [SW-1:0] scaled;

  always_comb begin
    prod_ab = a * b;
    prod_cd = c * d;
    ext_ab  = {prod_ab[PW-1], prod_ab};
    ext_cd  = {prod_cd[PW-1], prod_cd};
  end

  generate
    if (OP == ROT_ADD) begin : g_add
      always_comb acc = ext_ab + ext_cd;
    end else begin : g_sub
      always_comb acc = ext_ab - ext_cd;
    end
  endgenerate

  always_comb begin
    rounded = acc + HALF;
    scaled  = rounded >>> FRAC;
    if (scaled > MAXV) begin
      y = MAXV[DW-1:0];
    end else if (scaled < MINV) begin
      y = MINV[DW-1:0];
    end else begin
      y = scaled[DW-1:0];
    end
  end

endmodule

// File: rtl/qrot_rotator.sv
// Rotates a (sin, cos) pair by the step angle given as (k_sin, k_cos)
module qrot_rotator
  import qrot_pkg::*;
#(
  parameter int DW   = 16,
  parameter int FRAC = 14
) (
  input  logic signed [DW-1:0] cur_sin,
  input  logic signed [DW-1:0] cur_cos,
  input  logic signed [DW-1:0] k_sin,
  input  logic signed [DW-1:0] k_cos,
  output logic signed [DW-1:0] nxt_sin,
  output logic signed [DW-1:0] nxt_cos
);

  logic signed [DW-1:0] lane_a [NUM_LANES];
  logic signed [DW-1:0] lane_c [NUM_LANES];
  logic signed [DW-1:0] lane_y [NUM_LANES];

  // sin' = sin*kc + cos*ks ; cos' = cos*kc - sin*ks
  always_comb begin
    lane_a[LANE_SIN] = cur_sin;
    lane_c[LANE_SIN] = cur_cos;
    lane_a[LANE_COS] = cur_cos;
    lane_c[LANE_COS] = cur_sin;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_LANES; g++) begin : g_lane
      localparam rot_op_e LOP = (g == LANE_COS) ? ROT_SUB : ROT_ADD;
      qrot_rotmac #(
        .DW  (DW),
        .FRAC(FRAC),
        .OP  (LOP)
      ) u_mac (
        .a(lane_a[g]),
        .b(k_cos),
        .c(lane_c[g]),
        .d(k_sin),
        .y(lane_y[g])
      );
    end
  endgenerate

  assign nxt_sin = lane_y[LANE_SIN];
  assign nxt_cos = lane_y[LANE_COS];

endmodule

// File: rtl/qrot_osc.sv
// Quadrature rotation oscillator: state register plus one rotation per enabled clock
module qrot_osc #(
  parameter int DW   = 16,
  parameter int FRAC = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 load,
  input  logic signed [DW-1:0] ld_sin,
  input  logic signed [DW-1:0] ld_cos,
  input  logic signed [DW-1:0] k_sin,
  input  logic signed [DW-1:0] k_cos,
  output logic signed [DW-1:0] sin_out,
  output logic signed [DW-1:0] cos_out,
  output logic                 out_valid
);

  localparam logic signed [DW-1:0] UNIT = DW'(1) << FRAC;

  logic signed [DW-1:0] nxt_sin;
  logic signed [DW-1:0] nxt_cos;

  qrot_rotator #(
    .DW  (DW),
    .FRAC(FRAC)
  ) u_rot (
    .cur_sin(sin_out),
    .cur_cos(cos_out),
    .k_sin  (k_sin),
    .k_cos  (k_cos),
    .nxt_sin(nxt_sin),
    .nxt_cos(nxt_cos)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sin_out   <= '0;
      cos_out   <= UNIT;
      out_valid <= 1'b0;
    end else if (load) begin
      sin_out   <= ld_sin;
      cos_out   <= ld_cos;
      out_valid <= 1'b0;
    end else begin
      if (en) begin
        sin_out <= nxt_sin;
        cos_out <= nxt_cos;
      end
      out_valid <= en;
    end
  end

  // Checks
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    rst_seen |-> (sin_out == '0 && cos_out == UNIT && !out_valid));

  // R2 R3
  rotate_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> (sin_out == $past(nxt_sin) && cos_out == $past(nxt_cos)));

  // R5
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> ($stable(sin_out) && $stable(cos_out) && !out_valid));

  // R6
  valid_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> out_valid);

  // R7
  load_path_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (sin_out == $past(ld_sin) && cos_out == $past(ld_cos) && !out_valid));

endmodule

// File: tb/qrot_osc_tb.sv
`timescale 1ns/1ps
module qrot_osc_tb;

  localparam int DW   = 16;
  localparam int FRAC = 14;
  localparam int UNIT = 1 << FRAC;
  localparam real PI  = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic load = 1'b0;
  logic signed [DW-1:0] ld_sin = '0;
  logic signed [DW-1:0] ld_cos = '0;
  logic signed [DW-1:0] k_sin = '0;
  logic signed [DW-1:0] k_cos = '0;
  logic signed [DW-1:0] sin_out;
  logic signed [DW-1:0] cos_out;
  logic out_valid;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  qrot_osc #(.DW(DW), .FRAC(FRAC)) u_dut (
    .clk(clk), .rst(rst), .en(en), .load(load),
    .ld_sin(ld_sin), .ld_cos(ld_cos), .k_sin(k_sin), .k_cos(k_cos),
    .sin_out(sin_out), .cos_out(cos_out), .out_valid(out_valid)
  );

  function automatic int sat_round(longint acc);
    longint r;
    r = (acc + longint'(1 << (FRAC - 1))) >>> FRAC;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  function automatic int rnd(real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive at the falling edge, let one rising edge pass, sample at the next falling edge
  task automatic tick(input logic e, input logic l);
    en = e;
    load = l;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(1'b0, 1'b0);
    rst = 1'b0;
    check(sin_out == 0, "R1 sin", int'(sin_out), 0);
    check(cos_out == UNIT, "R1 cos", int'(cos_out), UNIT);
    check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int ms, mc, ts, tc;
    @(negedge clk);

    // Sweep over eight step angles with a gated enable pattern
    for (int a = 0; a < 8; a++) begin
      real ang;
      ang = 2.0 * PI * real'(a + 1) / 11.0;
      k_sin = DW'(rnd(real'(UNIT) * $sin(ang)));
      k_cos = DW'(rnd(real'(UNIT) * $cos(ang)));
      do_reset();
      ms = 0;
      mc = UNIT;
      for (int i = 0; i < 300; i++) begin
        logic e;
        e = ((i * 7 + a) % 5) != 0;
        tick(e, 1'b0);
        if (e) begin
          ts = sat_round(longint'(ms) * k_cos + longint'(mc) * k_sin);
          tc = sat_round(longint'(mc) * k_cos - longint'(ms) * k_sin);
          ms = ts;
          mc = tc;
        end
        // R2 R3 when enabled, R5 hold otherwise
        check(sin_out == ms, e ? "R2 sin step" : "R5 sin hold", int'(sin_out), ms);
        check(cos_out == mc, e ? "R3 cos step" : "R5 cos hold", int'(cos_out), mc);
        // R6 valid per enabled cycle, R5 low when idle
        check(out_valid == e, e ? "R6 valid" : "R5 valid", int'(out_valid), int'(e));
      end
    end

    // R4 clamp at the top: (32767,32767) with kc = ks = 1.0
    k_sin = DW'(UNIT);
    k_cos = DW'(UNIT);
    ld_sin = 16'sd32767;
    ld_cos = 16'sd32767;
    tick(1'b0, 1'b1);
    check(sin_out == 32767 && cos_out == 32767, "R7 load", int'(sin_out), 32767);
    check(out_valid == 1'b0, "R7 valid", int'(out_valid), 0);
    tick(1'b1, 1'b0);
    check(sin_out == 32767, "R4 clamp high", int'(sin_out), 32767);
    check(cos_out == 0, "R4 cos", int'(cos_out), 0);

    // R4 clamp at the bottom
    ld_sin = -16'sd32768;
    ld_cos = -16'sd32768;
    tick(1'b0, 1'b1);
    tick(1'b1, 1'b0);
    check(sin_out == -32768, "R4 clamp low", int'(sin_out), -32768);
    check(cos_out == 0, "R4 cos", int'(cos_out), 0);

    // R4 mixed signs: cos = 32767 - (-32768) clamps high, sin = -1
    ld_sin = -16'sd32768;
    ld_cos = 16'sd32767;
    tick(1'b0, 1'b1);
    tick(1'b1, 1'b0);
    check(cos_out == 32767, "R4 clamp mixed", int'(cos_out), 32767);
    check(sin_out == -1, "R4 sin mixed", int'(sin_out), -1);

    // R7 load wins over en
    ld_sin = 16'sd1234;
    ld_cos = -16'sd4321;
    tick(1'b1, 1'b1);
    check(sin_out == 1234, "R7 load over en", int'(sin_out), 1234);
    check(cos_out == -4321, "R7 load over en", int'(cos_out), -4321);
    check(out_valid == 1'b0, "R7 valid", int'(out_valid), 0);

    // R1 reset wins over load and en
    rst = 1'b1;
    tick(1'b1, 1'b1);
    rst = 1'b0;
    check(sin_out == 0 && cos_out == UNIT, "R1 over load", int'(cos_out), UNIT);
    check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);

    // Long run with constants close to the unit circle
    begin
      int best_c, best_s;
      longint best_err;
      real theta, max_ref, max_amp, amp;
      best_err = 64'sd1 << 40;
      best_c = 0;
      best_s = 0;
      for (int k = -100; k <= 100; k++) begin
        int c, s;
        longint err;
        c = rnd(real'(UNIT) * $cos(2.0 * PI / 37.0)) + k;
        s = rnd($sqrt(real'(UNIT) * real'(UNIT) - real'(c) * real'(c)));
        err = longint'(s) * s + longint'(c) * c - (longint'(UNIT) * UNIT);
        if (err < 0) err = -err;
        if (err < best_err) begin
          best_err = err;
          best_c = c;
          best_s = s;
        end
      end
      k_sin = DW'(best_s);
      k_cos = DW'(best_c);
      theta = $atan2(real'(best_s), real'(best_c));
      do_reset();
      ms = 0;
      mc = UNIT;
      max_ref = 0.0;
      max_amp = 0.0;
      for (int n = 1; n <= 10000; n++) begin
        tick(1'b1, 1'b0);
        ts = sat_round(longint'(ms) * k_cos + longint'(mc) * k_sin);
        tc = sat_round(longint'(mc) * k_cos - longint'(ms) * k_sin);
        ms = ts;
        mc = tc;
        check(sin_out == ms && cos_out == mc, "R2 R3 long run", int'(sin_out), ms);
        if (n <= 2000) begin
          real es, ec;
          es = real'(sin_out) - real'(UNIT) * $sin(real'(n) * theta);
          ec = real'(cos_out) - real'(UNIT) * $cos(real'(n) * theta);
          if (es < 0.0) es = -es;
          if (ec < 0.0) ec = -ec;
          if (es > max_ref) max_ref = es;
          if (ec > max_ref) max_ref = ec;
        end
        amp = $sqrt(real'(sin_out) * real'(sin_out) + real'(cos_out) * real'(cos_out))
              - real'(UNIT);
        if (amp < 0.0) amp = -amp;
        if (amp > max_amp) max_amp = amp;
      end
      check(max_ref <= 164.0, "R8 reference error", $rtoi(max_ref), 164);
      check(max_amp <= 0.03 * real'(UNIT), "R9 amplitude drift", $rtoi(max_amp),
            $rtoi(0.03 * real'(UNIT)));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule